// File: doc/BRIEF.md
# Embedded-Operation Status Bit Generator

This block is the device-side logic of a flash bank that answers reads with toggling status bits while an embedded program or erase is running or suspended. A controller outside the block reports the operation state. Per-sector erase-selection and protection flags are inputs, and so is a one-cycle strobe that marks the last write-enable rising edge of a command. Every read strobe returns a registered result a cycle later. The result says whether the read returns a status word or array data, and it carries the two toggle bits, the busy bit (bit 6) and the sector-erase bit (bit 2).

A program aimed at a protected sector opens a timed false-busy window. So does an erase whose selected sectors are all protected. While the window is open, reads return toggling status even though no operation runs. The window lengths are given in microseconds and converted to cycles from a clock-frequency parameter. A bench can therefore shorten them by lowering that frequency.

Top module: `emb_status_gen`

## Requirements
- R1: `op_state` is coded 0 idle, 1 program, 2 erase, 3 erase-suspended, 4 program during erase suspend. In states 1, 2 and 4, every read returns status (`rd_is_status`=1) and inverts `st_bit6` relative to the previous read.
- R2: A read strobed on the first clock edge after a `cmd_done` pulse that opens a false-busy window already returns status with `st_bit6` inverted.
- R3: In state 0 with no window open, reads return array data (`rd_is_status`=0), and neither `st_bit6` nor `st_bit2` changes.
- R4: In state 3, reads return status and `st_bit6` holds its value.
- R5: In states 2 and 3, a read of a sector whose `erase_sel` bit is 1 inverts `st_bit2`. A read of an unselected sector leaves it unchanged. In states 1 and 4, `st_bit2` never changes.
- R6: If `cmd_done` arrives with `cmd_prog`=1 and `prot[cmd_sector]`=1, exactly (CLK_HZ/1000)*PROG_FB_US/1000 consecutive read cycles after it see busy toggling of `st_bit6` (`st_bit2` held). Reads after that return array data.
- R7: If `cmd_done` arrives with `cmd_prog`=0, `erase_sel` nonzero and every selected sector protected, (CLK_HZ/1000)*ERASE_FB_US/1000 read cycles see busy toggling. During those cycles, `st_bit2` follows the selected-sector rule of R5.
- R8: No window opens for a program to an unprotected sector, or for an erase with an unprotected selected sector or with no sector selected.
- R9: `rd_valid` is 1 exactly in the cycle after each `rd_stb`, and 0 otherwise.
- R10: After reset, `rd_valid`, `rd_is_status`, `st_bit6` and `st_bit2` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_state | input | 3 | Embedded operation state code (see R1) |
| erase_sel | input | NSEC | Sector selected for erase, one bit per sector |
| prot | input | NSEC | Sector protected, one bit per sector |
| rd_stb | input | 1 | Read strobe |
| rd_sector | input | SEC_W | Sector addressed by the read |
| cmd_done | input | 1 | One-cycle pulse at the final write-enable rising edge of a command |
| cmd_prog | input | 1 | With cmd_done: 1 program command, 0 erase command |
| cmd_sector | input | SEC_W | With cmd_done: program target sector |
| rd_valid | output | 1 | Read result valid |
| rd_is_status | output | 1 | 1 status word, 0 array data |
| st_bit6 | output | 1 | Busy toggle bit |
| st_bit2 | output | 1 | Sector-erase toggle bit |

## Verification
Every read result is registered once, so it is due on the edge that samples `rd_stb`. The bench raises the strobe after a falling edge and checks the outputs at the next falling edge, before it issues another read. Windows are loaded on the edge that samples `cmd_done`. The read on the next edge is window cycle one, so the bench counts reads issued back to back from the pulse. It expects status for exactly the computed number of them and array data for the read that follows.

// File: rtl/esg_pkg.sv
package esg_pkg;
  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_ESUSP  = 3'd3,
    OP_ESPROG = 3'd4
  } op_e;

  function automatic int unsigned us_to_cycles(input int unsigned clk_hz, input int unsigned us);
    return (clk_hz / 1000) * us / 1000;
  endfunction
endpackage

// File: rtl/esg_fb_timer.sv
module esg_fb_timer #(
  parameter int unsigned ERASE_CYC = 10,
  parameter int unsigned PROG_CYC  = 100,
  parameter int unsigned CNT_W     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_done,
  input  logic cmd_prog,
  input  logic prog_tgt_prot,
  input  logic erase_all_prot,
  output logic win_act,
  output logic win_erase
);
  localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC);
  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             kind_q, kind_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    kind_d = kind_q;
    cnt_en = 1'b0;
    if (cmd_done && cmd_prog && prog_tgt_prot) begin
      cnt_d  = PROG_LD;
      kind_d = 1'b0;
      cnt_en = 1'b1;
    end else if (cmd_done && !cmd_prog && erase_all_prot) begin
      cnt_d  = ERASE_LD;
      kind_d = 1'b1;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      kind_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
    end
  end

  assign win_act   = (cnt_q != '0);
  assign win_erase = kind_q;
endmodule

// File: rtl/esg_read_path.sv
module esg_read_path (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic show,
  input  logic tog6,
  input  logic tog2,
  output logic rd_valid,
  output logic rd_is_status,
  output logic st_bit6,
  output logic st_bit2
);
  logic vld_d, sts_d, b6_d, b2_d;
  logic upd_en;

  always_comb begin
    vld_d  = rd_stb;
    sts_d  = show;
    b6_d   = st_bit6 ^ tog6;
    b2_d   = st_bit2 ^ tog2;
    upd_en = rd_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_is_status <= 1'b0;
      st_bit6      <= 1'b0;
      st_bit2      <= 1'b0;
    end else if (upd_en) begin
      rd_is_status <= sts_d;
      st_bit6      <= b6_d;
      st_bit2      <= b2_d;
    end
  end
endmodule

// File: rtl/emb_status_gen.sv
module emb_status_gen #(
  parameter int unsigned NSEC        = 16,
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned ERASE_FB_US = 100,
  parameter int unsigned PROG_FB_US  = 1000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                op_state,
  input  logic [NSEC-1:0]           erase_sel,
  input  logic [NSEC-1:0]           prot,
  input  logic                      rd_stb,
  input  logic [$clog2(NSEC)-1:0]   rd_sector,
  input  logic                      cmd_done,
  input  logic                      cmd_prog,
  input  logic [$clog2(NSEC)-1:0]   cmd_sector,
  output logic                      rd_valid,
  output logic                      rd_is_status,
  output logic                      st_bit6,
  output logic                      st_bit2
);
  import esg_pkg::*;

  localparam int unsigned SEC_W     = $clog2(NSEC);
  localparam int unsigned ERASE_CYC = us_to_cycles(CLK_HZ, ERASE_FB_US);
  localparam int unsigned PROG_CYC  = us_to_cycles(CLK_HZ, PROG_FB_US);
  localparam int unsigned MAX_CYC   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1) + 1;

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  op_e  op;
  logic win_act, win_erase;
  logic prog_tgt_prot, erase_all_prot;
  logic busy_op, erase_ctx, show, tog6, tog2;

  assign op             = op_e'(op_state);
  assign prog_tgt_prot  = prot[cmd_sector];
  assign erase_all_prot = (erase_sel != '0) && ((erase_sel & ~prot) == '0);

  always_comb begin
    busy_op   = (op == OP_PROG) || (op == OP_ERASE) || (op == OP_ESPROG);
    erase_ctx = (op == OP_ERASE) || (op == OP_ESUSP) || (win_act && win_erase);
    show      = (op != OP_IDLE) || win_act;
    tog6      = busy_op || win_act;
    tog2      = erase_ctx && erase_sel[rd_sector];
  end

  esg_fb_timer #(
    .ERASE_CYC (ERASE_CYC),
    .PROG_CYC  (PROG_CYC),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .cmd_done       (cmd_done),
    .cmd_prog       (cmd_prog),
    .prog_tgt_prot  (prog_tgt_prot),
    .erase_all_prot (erase_all_prot),
    .win_act        (win_act),
    .win_erase      (win_erase)
  );

  esg_read_path u_rd (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .rd_stb       (rd_stb),
    .show         (show),
    .tog6         (tog6),
    .tog2         (tog2),
    .rd_valid     (rd_valid),
    .rd_is_status (rd_is_status),
    .st_bit6      (st_bit6),
    .st_bit2      (st_bit2)
  );
endmodule

// File: rtl/esg_sva.sv
module esg_sva #(
  parameter int unsigned NSEC  = 16,
  parameter int unsigned SEC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op_state,
  input logic [NSEC-1:0]  erase_sel,
  input logic [NSEC-1:0]  prot,
  input logic             rd_stb,
  input logic [SEC_W-1:0] rd_sector,
  input logic             cmd_done,
  input logic             cmd_prog,
  input logic [SEC_W-1:0] cmd_sector,
  input logic             win_act,
  input logic             rd_valid,
  input logic             rd_is_status,
  input logic             st_bit6,
  input logic             st_bit2
);
  // R1: busy states flip bit 6 on every read
  a_r1_busy_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (op_state == 3'd1 || op_state == 3'd2 || op_state == 3'd4))
      |=> (rd_is_status && st_bit6 != $past(st_bit6)));

  // R3: idle without window returns array data
  a_r3_idle_array: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && op_state == 3'd0 && !win_act) |=> (!rd_is_status && $stable(st_bit6)));

  // R4: suspended erase holds bit 6
  a_r4_susp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && op_state == 3'd3 && !win_act) |=> (rd_is_status && $stable(st_bit6)));

  // R5: unselected sector never moves bit 2
  a_r5_unsel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !erase_sel[rd_sector]) |=> $stable(st_bit2));

  // R6: protected program target opens a window
  a_r6_prog_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && cmd_prog && prot[cmd_sector]) |=> win_act);

  // R9: valid strictly follows the strobe
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);
  a_r9_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid);
endmodule

bind emb_status_gen esg_sva #(.NSEC(NSEC), .SEC_W(SEC_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .op_state     (op_state),
  .erase_sel    (erase_sel),
  .prot         (prot),
  .rd_stb       (rd_stb),
  .rd_sector    (rd_sector),
  .cmd_done     (cmd_done),
  .cmd_prog     (cmd_prog),
  .cmd_sector   (cmd_sector),
  .win_act      (win_act),
  .rd_valid     (rd_valid),
  .rd_is_status (rd_is_status),
  .st_bit6      (st_bit6),
  .st_bit2      (st_bit2)
);

// File: tb/tb_emb_status_gen.sv
module tb_emb_status_gen;
  localparam int NSEC  = 4;
  localparam int SEC_W = 2;
  localparam int HZ    = 100_000;
  localparam int E_WIN = (HZ / 1000) * 100 / 1000;   // 10 cycles
  localparam int P_WIN = (HZ / 1000) * 1000 / 1000;  // 100 cycles

  logic clk, rst_n;
  logic [2:0] op_state;
  logic [NSEC-1:0] erase_sel, prot;
  logic rd_stb, cmd_done, cmd_prog;
  logic [SEC_W-1:0] rd_sector, cmd_sector;
  logic rd_valid, rd_is_status, st_bit6, st_bit2;

  int n_chk, n_fail;
  bit m6, m2, done;

  emb_status_gen #(.NSEC(NSEC), .CLK_HZ(HZ), .ERASE_FB_US(100), .PROG_FB_US(1000)) dut (
    .clk(clk), .rst_n(rst_n), .op_state(op_state), .erase_sel(erase_sel), .prot(prot),
    .rd_stb(rd_stb), .rd_sector(rd_sector), .cmd_done(cmd_done), .cmd_prog(cmd_prog),
    .cmd_sector(cmd_sector), .rd_valid(rd_valid), .rd_is_status(rd_is_status),
    .st_bit6(st_bit6), .st_bit2(st_bit2));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {valid,status,b6,b2} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_read(input int sec, input bit exp_st, input bit t6, input bit t2, input string tag);
    rd_sector = SEC_W'(sec);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    m6 ^= t6;
    m2 ^= t2;
    check(tag, {rd_valid, rd_is_status, st_bit6, st_bit2}, {1'b1, exp_st, m6, m2});
  endtask

  task automatic pulse_cmd(input bit prog, input int sec);
    cmd_prog = prog;
    cmd_sector = SEC_W'(sec);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; m6 = 0; m2 = 0; done = 0;
    rst_n = 1'b0; op_state = 3'd0; erase_sel = '0; prot = '0;
    rd_stb = 1'b0; rd_sector = '0; cmd_done = 1'b0; cmd_prog = 1'b0; cmd_sector = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 reset", {rd_valid, rd_is_status, st_bit6, st_bit2}, 4'b0000);

    // R3 idle: array data, no toggling
    for (int s = 0; s < NSEC; s++) do_read(s, 1'b0, 1'b0, 1'b0, "R3 idle");

    // R9 valid drops when no strobe
    @(negedge clk);
    check("R9 no strobe", {rd_valid, 3'b000}, 4'b0000);

    // R1 program: bit6 flips, R5 bit2 held
    op_state = 3'd1; erase_sel = 4'b0101;
    for (int s = 0; s < 2 * NSEC; s++) do_read(s % NSEC, 1'b1, 1'b1, 1'b0, "R1/R5 program");

    // R1/R5 erase: bit2 flips only on selected sectors
    op_state = 3'd2;
    for (int s = 0; s < 2 * NSEC; s++)
      do_read(s % NSEC, 1'b1, 1'b1, erase_sel[s % NSEC], "R1/R5 erase");

    // R4/R5 erase suspend: bit6 held, bit2 still flips on selected
    op_state = 3'd3;
    for (int s = 0; s < 2 * NSEC; s++)
      do_read(s % NSEC, 1'b1, 1'b0, erase_sel[s % NSEC], "R4/R5 suspend");

    // R1/R5 program during suspend
    op_state = 3'd4;
    for (int s = 0; s < NSEC; s++) do_read(s, 1'b1, 1'b1, 1'b0, "R1/R5 suspend-program");

    // R3 back to idle
    op_state = 3'd0; erase_sel = '0;
    do_read(1, 1'b0, 1'b0, 1'b0, "R3 idle again");

    // R8 program to unprotected sector: no window
    prot = 4'b0100;
    pulse_cmd(1'b1, 0);
    do_read(0, 1'b0, 1'b0, 1'b0, "R8 unprotected program");

    // R2/R6 program to protected sector: P_WIN status reads
    pulse_cmd(1'b1, 2);
    for (int i = 1; i <= P_WIN + 2; i++)
      do_read(i % NSEC, i <= P_WIN, i <= P_WIN, 1'b0, (i == 1) ? "R2 first read" : "R6 program window");

    // R8 erase with one unprotected selected sector: no window
    erase_sel = 4'b0011; prot = 4'b0001;
    pulse_cmd(1'b0, 0);
    do_read(1, 1'b0, 1'b0, 1'b0, "R8 mixed erase");

    // R8 erase with nothing selected: no window
    erase_sel = 4'b0000; prot = 4'b1111;
    pulse_cmd(1'b0, 0);
    do_read(0, 1'b0, 1'b0, 1'b0, "R8 empty erase");

    // R7 all-protected erase: E_WIN cycles, bit2 on selected sectors
    erase_sel = 4'b0011; prot = 4'b0111;
    pulse_cmd(1'b0, 3);
    for (int i = 1; i <= E_WIN + 2; i++)
      do_read(i % NSEC, i <= E_WIN, i <= E_WIN, (i <= E_WIN) && erase_sel[i % NSEC], "R7 erase window");

    // R9 after the last read
    @(negedge clk);
    check("R9 quiet", {rd_valid, 3'b000}, 4'b0000);

    finish_run();
  end
endmodule